// File: doc/BRIEF.md
# Masked-Window Status and Interrupt Register Bank

This block holds the three machine-level control registers of a hart: the status word, the interrupt-pending word and the interrupt-enable word. The supervisor and user copies of these registers have no flops of their own. Each one is a masked window onto its machine register. Reading a window returns the machine value ANDed with that window's mask. Writing a window merges the new data into the machine register under the mask, so every bit outside the window keeps its value. The masks come from a two-bit input that tells the bank which privilege modes the hart implements. The bank also holds the floating-point accrued-flags and rounding-mode fields, plus a combined alias that covers both.

The bank has one read port and one write port, each addressed by a 12-bit register address. A read is combinational and always completes in its own cycle. A write is applied at the next rising clock edge. Neither port can stall, so there is no back-pressure and no handshake: a caller can read or write every cycle. A read and a write in the same cycle are both legal. The read returns the value from before the write, and the written value is visible from the following cycle on. Interrupt sources, trap entry and counters live outside this block.

Top module: `csr_alias_bank`

## Requirements
- R1: After reset, every register reads as zero, with one exception. When XLEN is 64, the machine status word reads 0xA_0000_0000: the two fixed width fields hold 2'b10.
- R2: Address 0x100 (status), 0x144 (pending) and 0x104 (enable) are the supervisor windows. Each reads as the machine register ANDed with the supervisor mask. The status mask is bits 1, 5, 8, 13, 14, 18 and 19; it adds bits 0 and 4 when user mode exists, and bits 33:32 when XLEN is 64. The interrupt mask is bits 1, 5 and 9.
- R3: Address 0x000 (status), 0x044 (pending) and 0x004 (enable) are the user windows. They use the user mask: status bits 0 and 4, and interrupt bits 0, 4 and 8.
- R4: A write to a window stores (data AND mask) OR (current AND NOT mask) into the machine register. Bits outside the window keep their old value.
- R5: Address 0x344 (machine pending) and 0x304 (machine enable) keep only the machine interrupt mask on write. That mask is bits 3, 7 and 11, plus bits 1, 5 and 9 when supervisor mode exists, plus bits 0, 4 and 8 when user mode exists.
- R6: Address 0x300 (machine status) keeps only the status write mask on write. That mask is bits 3, 7, 11, 12, 13 and 14; plus bits 1, 5, 8, 18 and 19 with supervisor mode; plus bits 0, 4 and 17 with user mode. A merged window write passes through this same mask.
- R7: When XLEN is 64, machine status bits [35:34] and [33:32] always read 2'b10, whatever value is written.
- R8: Address 0x001 (flags) keeps 5 bits on write, and 0x002 (rounding mode) keeps 3 bits. A write to 0x003 (combined) sends bits [4:0] to flags and bits [7:5] to rounding mode. A read of 0x003 returns {mode, flags}.
- R9: impl_modes bit 1 means supervisor mode exists, and bit 0 means user mode exists. The window of a mode that is absent reads as zero and ignores writes.
- R10: An address that is not listed above drops rd_hit and reads as zero. A write to it changes no register.
- R11: A write becomes visible at the rising edge that samples wr_en. A read in that same cycle returns the old value, and a register holds its value in any cycle without a write to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| impl_modes | input | 2 | Bit 1: supervisor mode exists; bit 0: user mode exists |
| rd_addr | input | 12 | Read address |
| rd_hit | output | 1 | High when rd_addr names a register of this bank |
| rd_data | output | XLEN | Read data, zero-extended |
| wr_en | input | 1 | Write strobe, applied at the next rising edge |
| wr_addr | input | 12 | Write address |
| wr_data | input | XLEN | Write data |

## Verification
Wrong stored state in a machine register shows up on the very next read of that register, or of any window onto it. Reads are combinational, so the fault is visible one cycle after the faulty write. A wrong mask, on the other hand, is a purely combinational fault. It shows up in the same cycle as the read, and it also shows up one cycle later as a leaked or lost bit in the machine register after a window write. That is why the bench re-reads every address after each write, including the machine registers behind a window, and repeats the accesses under several implemented-mode settings.

// File: rtl/csr_alias_pkg.sv
package csr_alias_pkg;

  localparam int CSR_AW = 12;

  // register addresses decoded by the bank
  localparam logic [CSR_AW-1:0] A_STAT_U = 12'h000;
  localparam logic [CSR_AW-1:0] A_FLAGS  = 12'h001;
  localparam logic [CSR_AW-1:0] A_RMODE  = 12'h002;
  localparam logic [CSR_AW-1:0] A_FPALL  = 12'h003;
  localparam logic [CSR_AW-1:0] A_IEN_U  = 12'h004;
  localparam logic [CSR_AW-1:0] A_IPND_U = 12'h044;
  localparam logic [CSR_AW-1:0] A_STAT_S = 12'h100;
  localparam logic [CSR_AW-1:0] A_IEN_S  = 12'h104;
  localparam logic [CSR_AW-1:0] A_IPND_S = 12'h144;
  localparam logic [CSR_AW-1:0] A_STAT_M = 12'h300;
  localparam logic [CSR_AW-1:0] A_IEN_M  = 12'h304;
  localparam logic [CSR_AW-1:0] A_IPND_M = 12'h344;

  // status field groups (64-bit, sliced to XLEN by users)
  localparam logic [63:0] ST_ALWAYS = 64'h0000_0000_0000_7888;
  localparam logic [63:0] ST_SUPV   = 64'h0000_0000_000C_0122;
  localparam logic [63:0] ST_USER   = 64'h0000_0000_0002_0011;
  localparam logic [63:0] ST_FPST   = 64'h0000_0000_0000_6000;
  localparam logic [63:0] ST_UWIN   = 64'h0000_0000_0000_0011;
  localparam logic [63:0] XL_FIELDS = 64'h0000_000F_0000_0000;
  localparam logic [63:0] XL_VALUE  = 64'h0000_000A_0000_0000;
  localparam logic [63:0] XL_UPART  = 64'h0000_0003_0000_0000;

  // interrupt bit groups
  localparam logic [63:0] IRQ_MACH = 64'h888;
  localparam logic [63:0] IRQ_SUPV = 64'h222;
  localparam logic [63:0] IRQ_USER = 64'h111;

  localparam int FLAG_W = 5;
  localparam int RM_W   = 3;
  localparam int FP_W   = FLAG_W + RM_W;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_STAT,
    TGT_IPND,
    TGT_IEN,
    TGT_FLAGS,
    TGT_RMODE,
    TGT_FPALL
  } csr_tgt_e;

  typedef enum logic [1:0] {
    LVL_M,
    LVL_S,
    LVL_U
  } csr_lvl_e;

  typedef struct packed {
    csr_tgt_e tgt;
    csr_lvl_e lvl;
  } csr_sel_t;

  function automatic csr_sel_t csr_decode(input logic [CSR_AW-1:0] a);
    csr_sel_t s;
    s.tgt = TGT_NONE;
    s.lvl = LVL_M;
    case (a)
      A_STAT_M: s.tgt = TGT_STAT;
      A_IPND_M: s.tgt = TGT_IPND;
      A_IEN_M:  s.tgt = TGT_IEN;
      A_STAT_S: begin s.tgt = TGT_STAT; s.lvl = LVL_S; end
      A_IPND_S: begin s.tgt = TGT_IPND; s.lvl = LVL_S; end
      A_IEN_S:  begin s.tgt = TGT_IEN;  s.lvl = LVL_S; end
      A_STAT_U: begin s.tgt = TGT_STAT; s.lvl = LVL_U; end
      A_IPND_U: begin s.tgt = TGT_IPND; s.lvl = LVL_U; end
      A_IEN_U:  begin s.tgt = TGT_IEN;  s.lvl = LVL_U; end
      A_FLAGS:  s.tgt = TGT_FLAGS;
      A_RMODE:  s.tgt = TGT_RMODE;
      A_FPALL:  s.tgt = TGT_FPALL;
      default:  s.tgt = TGT_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/csr_mask_gen.sv
module csr_mask_gen
  import csr_alias_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [1:0]      impl_modes,
  output logic [XLEN-1:0] st_wmask_m,
  output logic [XLEN-1:0] st_view_s,
  output logic [XLEN-1:0] st_view_u,
  output logic [XLEN-1:0] irq_wmask_m,
  output logic [XLEN-1:0] irq_view_s,
  output logic [XLEN-1:0] irq_view_u
);
  localparam logic [63:0] UXL64 = (XLEN == 64) ? XL_UPART : 64'h0;

  localparam logic [XLEN-1:0] K_ST_ALW  = ST_ALWAYS[XLEN-1:0];
  localparam logic [XLEN-1:0] K_ST_SUP  = ST_SUPV[XLEN-1:0];
  localparam logic [XLEN-1:0] K_ST_USR  = ST_USER[XLEN-1:0];
  localparam logic [XLEN-1:0] K_ST_FP   = ST_FPST[XLEN-1:0];
  localparam logic [XLEN-1:0] K_ST_UWIN = ST_UWIN[XLEN-1:0];
  localparam logic [XLEN-1:0] K_UXL     = UXL64[XLEN-1:0];
  localparam logic [XLEN-1:0] K_IRQ_M   = IRQ_MACH[XLEN-1:0];
  localparam logic [XLEN-1:0] K_IRQ_S   = IRQ_SUPV[XLEN-1:0];
  localparam logic [XLEN-1:0] K_IRQ_U   = IRQ_USER[XLEN-1:0];

  logic has_s, has_u;
  assign has_s = impl_modes[1];
  assign has_u = impl_modes[0];

  always_comb begin
    st_wmask_m = K_ST_ALW;
    if (has_s) st_wmask_m = st_wmask_m | K_ST_SUP;
    if (has_u) st_wmask_m = st_wmask_m | K_ST_USR;

    st_view_s = '0;
    if (has_s) begin
      st_view_s = K_ST_SUP | K_ST_FP | K_UXL;
      if (has_u) st_view_s = st_view_s | K_ST_UWIN;
    end

    st_view_u = has_u ? K_ST_UWIN : '0;

    irq_wmask_m = K_IRQ_M;
    if (has_s) irq_wmask_m = irq_wmask_m | K_IRQ_S;
    if (has_u) irq_wmask_m = irq_wmask_m | K_IRQ_U;

    irq_view_s = has_s ? K_IRQ_S : '0;
    irq_view_u = has_u ? K_IRQ_U : '0;
  end

endmodule

// File: rtl/csr_mreg.sv
module csr_mreg #(
  parameter int              XLEN     = 64,
  parameter logic [XLEN-1:0] FIX_MASK = '0,
  parameter logic [XLEN-1:0] FIX_VAL  = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [XLEN-1:0] wdata,
  input  logic [XLEN-1:0] wmask,
  output logic [XLEN-1:0] q
);
  logic [XLEN-1:0] nxt;

  always_comb begin
    nxt = (wdata & wmask & ~FIX_MASK) | FIX_VAL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= FIX_VAL;
    else if (we) q <= nxt;
  end

  // R11: without a write strobe the register holds
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

endmodule

// File: rtl/csr_fpflags.sv
module csr_fpflags
  import csr_alias_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_flags,
  input  logic              we_rm,
  input  logic              we_all,
  input  logic [FP_W-1:0]   wdata,
  output logic [FLAG_W-1:0] flags,
  output logic [RM_W-1:0]   rm
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      rm    <= '0;
    end else begin
      if (we_flags || we_all) flags <= wdata[FLAG_W-1:0];
      if (we_rm) rm <= wdata[RM_W-1:0];
      else if (we_all) rm <= wdata[FP_W-1:FLAG_W];
    end
  end

  // R8: combined write splits into both fields
  p_fcsr_split_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we_all && !we_rm && !we_flags |=> {rm, flags} == $past(wdata));

  // R11: no strobe, no change
  p_fp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_flags || we_rm || we_all) |=> $stable({rm, flags}));

endmodule

// File: rtl/csr_alias_bank.sv
module csr_alias_bank
  import csr_alias_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        impl_modes,
  input  logic [CSR_AW-1:0] rd_addr,
  output logic              rd_hit,
  output logic [XLEN-1:0]   rd_data,
  input  logic              wr_en,
  input  logic [CSR_AW-1:0] wr_addr,
  input  logic [XLEN-1:0]   wr_data
);
  localparam int NREG = 3;
  localparam logic [63:0] XLF64 = (XLEN == 64) ? XL_FIELDS : 64'h0;
  localparam logic [63:0] XLV64 = (XLEN == 64) ? XL_VALUE  : 64'h0;
  localparam logic [XLEN-1:0] K_XL_MASK = XLF64[XLEN-1:0];
  localparam logic [XLEN-1:0] K_XL_VAL  = XLV64[XLEN-1:0];

  // masks
  logic [XLEN-1:0] st_wmask_m, st_view_s, st_view_u;
  logic [XLEN-1:0] irq_wmask_m, irq_view_s, irq_view_u;

  csr_mask_gen #(.XLEN(XLEN)) u_masks (
    .impl_modes  (impl_modes),
    .st_wmask_m  (st_wmask_m),
    .st_view_s   (st_view_s),
    .st_view_u   (st_view_u),
    .irq_wmask_m (irq_wmask_m),
    .irq_view_s  (irq_view_s),
    .irq_view_u  (irq_view_u)
  );

  // storage: index 0 status, 1 pending, 2 enable
  logic [XLEN-1:0] mq     [NREG];
  logic [XLEN-1:0] mwmask [NREG];
  logic            mwe    [NREG];
  logic [XLEN-1:0] merged;

  assign mwmask[0] = st_wmask_m;
  assign mwmask[1] = irq_wmask_m;
  assign mwmask[2] = irq_wmask_m;

  for (genvar g = 0; g < NREG; g++) begin : g_mreg
    if (g == 0) begin : g_stat
      csr_mreg #(.XLEN(XLEN), .FIX_MASK(K_XL_MASK), .FIX_VAL(K_XL_VAL)) u_reg (
        .clk(clk), .rst_n(rst_n), .we(mwe[g]), .wdata(merged),
        .wmask(mwmask[g]), .q(mq[g]));
    end else begin : g_irq
      csr_mreg #(.XLEN(XLEN)) u_reg (
        .clk(clk), .rst_n(rst_n), .we(mwe[g]), .wdata(merged),
        .wmask(mwmask[g]), .q(mq[g]));
    end
  end

  // floating-point fields
  logic [FLAG_W-1:0] fp_flags;
  logic [RM_W-1:0]   fp_rm;
  logic              we_flags, we_rm, we_all;

  csr_fpflags u_fp (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_flags (we_flags),
    .we_rm    (we_rm),
    .we_all   (we_all),
    .wdata    (wr_data[FP_W-1:0]),
    .flags    (fp_flags),
    .rm       (fp_rm)
  );

  // select helpers
  function automatic logic [XLEN-1:0] view_mask(input csr_sel_t s,
                                                input logic [XLEN-1:0] sm_st,
                                                input logic [XLEN-1:0] um_st,
                                                input logic [XLEN-1:0] sm_irq,
                                                input logic [XLEN-1:0] um_irq);
    logic [XLEN-1:0] m;
    m = '1;
    if (s.lvl == LVL_S) m = (s.tgt == TGT_STAT) ? sm_st : sm_irq;
    else if (s.lvl == LVL_U) m = (s.tgt == TGT_STAT) ? um_st : um_irq;
    return m;
  endfunction

  function automatic logic [XLEN-1:0] fp_word(input logic [FLAG_W-1:0] f,
                                              input logic [RM_W-1:0] r,
                                              input csr_tgt_e t);
    logic [XLEN-1:0] w;
    w = '0;
    case (t)
      TGT_FLAGS: w[FLAG_W-1:0] = f;
      TGT_RMODE: w[RM_W-1:0]   = r;
      TGT_FPALL: w[FP_W-1:0]   = {r, f};
      default:   w = '0;
    endcase
    return w;
  endfunction

  // write path: merge under the window mask, then the machine mask
  csr_sel_t        wsel;
  logic [XLEN-1:0] wcur, wvmask;

  always_comb begin
    wsel   = csr_decode(wr_addr);
    wvmask = view_mask(wsel, st_view_s, st_view_u, irq_view_s, irq_view_u);
    case (wsel.tgt)
      TGT_STAT: wcur = mq[0];
      TGT_IPND: wcur = mq[1];
      TGT_IEN:  wcur = mq[2];
      default:  wcur = '0;
    endcase
    merged   = (wr_data & wvmask) | (wcur & ~wvmask);
    mwe[0]   = wr_en && (wsel.tgt == TGT_STAT);
    mwe[1]   = wr_en && (wsel.tgt == TGT_IPND);
    mwe[2]   = wr_en && (wsel.tgt == TGT_IEN);
    we_flags = wr_en && (wsel.tgt == TGT_FLAGS);
    we_rm    = wr_en && (wsel.tgt == TGT_RMODE);
    we_all   = wr_en && (wsel.tgt == TGT_FPALL);
  end

  // read path
  csr_sel_t        rsel;
  logic [XLEN-1:0] rbase, rvmask;

  always_comb begin
    rsel   = csr_decode(rd_addr);
    rvmask = view_mask(rsel, st_view_s, st_view_u, irq_view_s, irq_view_u);
    case (rsel.tgt)
      TGT_STAT: rbase = mq[0];
      TGT_IPND: rbase = mq[1];
      TGT_IEN:  rbase = mq[2];
      default:  rbase = fp_word(fp_flags, fp_rm, rsel.tgt);
    endcase
    rd_hit  = (rsel.tgt != TGT_NONE);
    rd_data = rd_hit ? (rbase & rvmask) : '0;
  end

  // checks
  logic wr_stat_s, rd_s_absent;
  assign wr_stat_s   = wr_en && (wsel.tgt == TGT_STAT) && (wsel.lvl == LVL_S);
  assign rd_s_absent = (rsel.tgt != TGT_NONE) && (rsel.lvl == LVL_S) && !impl_modes[1];

  // R4: a supervisor status write leaves bits outside its window alone
  p_view_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat_s |=> ((mq[0] & ~$past(st_view_s)) == ($past(mq[0]) & ~$past(st_view_s))));

  // R5: machine pending write stores nothing outside the interrupt mask
  p_irq_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wsel.tgt == TGT_IPND && wsel.lvl == LVL_M)
      |=> ((mq[1] & ~$past(irq_wmask_m)) == '0));

  // R9: absent supervisor mode makes its windows read zero
  p_absent_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_s_absent |-> rd_data == '0);

  // R10: unknown addresses read zero
  p_unknown_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> rd_data == '0);

  if (XLEN == 64) begin : g_xl_chk
    // R7: width fields of the machine status read fixed
    p_xl_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == A_STAT_M) |-> rd_data[35:32] == 4'b1010);
  end

endmodule

// File: tb/csr_alias_bank_tb.sv
module csr_alias_bank_tb;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      impl_modes = 2'b11;
  logic [11:0]     rd_addr = '0;
  logic            rd_hit;
  logic [XLEN-1:0] rd_data;
  logic            wr_en = 1'b0;
  logic [11:0]     wr_addr = '0;
  logic [XLEN-1:0] wr_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  csr_alias_bank #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .impl_modes(impl_modes),
    .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  // expected model built from the requirements
  logic [63:0] e_st, e_ip, e_ie;
  logic [4:0]  e_ff;
  logic [2:0]  e_rm;

  localparam logic [11:0] ADDRS [12] = '{12'h300, 12'h344, 12'h304, 12'h100,
    12'h144, 12'h104, 12'h000, 12'h044, 12'h004, 12'h001, 12'h002, 12'h003};

  function automatic logic [63:0] m_stw();
    return 64'h7888 | (impl_modes[1] ? 64'hC0122 : 64'h0) |
           (impl_modes[0] ? 64'h20011 : 64'h0);
  endfunction
  function automatic logic [63:0] m_sst();
    if (!impl_modes[1]) return 64'h0;
    return 64'hC0122 | 64'h6000 | 64'h3_0000_0000 | (impl_modes[0] ? 64'h11 : 64'h0);
  endfunction
  function automatic logic [63:0] m_ust();
    return impl_modes[0] ? 64'h11 : 64'h0;
  endfunction
  function automatic logic [63:0] m_irq();
    return 64'h888 | (impl_modes[1] ? 64'h222 : 64'h0) | (impl_modes[0] ? 64'h111 : 64'h0);
  endfunction
  function automatic logic [63:0] m_sirq();
    return impl_modes[1] ? 64'h222 : 64'h0;
  endfunction
  function automatic logic [63:0] m_uirq();
    return impl_modes[0] ? 64'h111 : 64'h0;
  endfunction

  function automatic logic [64:0] model_rd(input logic [11:0] a);
    case (a)
      12'h300: return {1'b1, e_st};
      12'h344: return {1'b1, e_ip};
      12'h304: return {1'b1, e_ie};
      12'h100: return {1'b1, e_st & m_sst()};
      12'h144: return {1'b1, e_ip & m_sirq()};
      12'h104: return {1'b1, e_ie & m_sirq()};
      12'h000: return {1'b1, e_st & m_ust()};
      12'h044: return {1'b1, e_ip & m_uirq()};
      12'h004: return {1'b1, e_ie & m_uirq()};
      12'h001: return {1'b1, 59'h0, e_ff};
      12'h002: return {1'b1, 61'h0, e_rm};
      12'h003: return {1'b1, 56'h0, e_rm, e_ff};
      default: return 65'h0;
    endcase
  endfunction

  task automatic model_wr(input logic [11:0] a, input logic [63:0] d);
    logic [63:0] vm, m;
    case (a)
      12'h300: e_st = (d & m_stw()) | 64'hA_0000_0000;
      12'h100, 12'h000: begin
        vm = (a == 12'h100) ? m_sst() : m_ust();
        m  = (d & vm) | (e_st & ~vm);
        e_st = (m & m_stw()) | 64'hA_0000_0000;
      end
      12'h344: e_ip = d & m_irq();
      12'h304: e_ie = d & m_irq();
      12'h144, 12'h044: begin
        vm = (a == 12'h144) ? m_sirq() : m_uirq();
        e_ip = ((d & vm) | (e_ip & ~vm)) & m_irq();
      end
      12'h104, 12'h004: begin
        vm = (a == 12'h104) ? m_sirq() : m_uirq();
        e_ie = ((d & vm) | (e_ie & ~vm)) & m_irq();
      end
      12'h001: e_ff = d[4:0];
      12'h002: e_rm = d[2:0];
      12'h003: begin e_ff = d[4:0]; e_rm = d[7:5]; end
      default: ;
    endcase
  endtask

  task automatic check(input string req, input string what,
                       input logic [64:0] got, input logic [64:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // called just after a negedge
  task automatic check_all(input string req);
    for (int i = 0; i < 12; i++) begin
      rd_addr = ADDRS[i];
      #0.5;
      check(req, $sformatf("read %h", ADDRS[i]), {rd_hit, rd_data}, model_rd(ADDRS[i]));
    end
  endtask

  task automatic dut_wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(a, d);
  endtask

  task automatic t_reset_r1();
    e_st = 64'hA_0000_0000; e_ip = '0; e_ie = '0; e_ff = '0; e_rm = '0;
    @(negedge clk);
    check_all("R1");
  endtask

  task automatic t_mstat_r6_r7();
    dut_wr(12'h300, '1);
    check_all("R6");
    dut_wr(12'h300, '0);
    rd_addr = 12'h300; #0.5;
    check("R7", "fixed width fields", {61'h0, rd_data[35:32]}, 65'hA);
    dut_wr(12'h300, 64'h5_0000_0000);
    check_all("R7");
  endtask

  task automatic t_irq_r5();
    dut_wr(12'h344, '1);
    dut_wr(12'h304, '1);
    check_all("R5");
    impl_modes = 2'b00;
    dut_wr(12'h304, '1);
    check_all("R5");
    impl_modes = 2'b11;
  endtask

  task automatic t_sview_r2_r4();
    dut_wr(12'h300, '1);
    check_all("R2");
    dut_wr(12'h100, '0);
    check_all("R4");
    dut_wr(12'h144, 64'hFFFF_0000_0000_0200);
    check_all("R4");
    dut_wr(12'h104, 64'h20);
    check_all("R2");
  endtask

  task automatic t_uview_r3();
    dut_wr(12'h000, '1);
    check_all("R3");
    dut_wr(12'h044, 64'h100);
    dut_wr(12'h004, 64'hFFE);
    check_all("R3");
  endtask

  task automatic t_fp_r8();
    dut_wr(12'h001, 64'hFF);
    dut_wr(12'h002, 64'hFF);
    check_all("R8");
    dut_wr(12'h003, 64'hFFFF_FFA5);
    check_all("R8");
    rd_addr = 12'h003; #0.5;
    check("R8", "combined read", {rd_hit, rd_data}, {1'b1, 64'hA5});
  endtask

  task automatic t_absent_r9();
    dut_wr(12'h344, '1);
    dut_wr(12'h304, '1);
    impl_modes = 2'b01;
    @(negedge clk);
    check_all("R9");
    dut_wr(12'h144, '0);
    dut_wr(12'h100, '0);
    check_all("R9");
    impl_modes = 2'b10;
    dut_wr(12'h044, '0);
    dut_wr(12'h000, '0);
    check_all("R9");
    impl_modes = 2'b11;
  endtask

  task automatic t_unknown_r10();
    rd_addr = 12'h7C0; #0.5;
    check("R10", "unknown read", {rd_hit, rd_data}, 65'h0);
    dut_wr(12'h7C0, '1);
    dut_wr(12'h305, '1);
    check_all("R10");
  endtask

  task automatic t_timing_r11();
    logic [64:0] old_v;
    @(negedge clk);
    old_v = model_rd(12'h304);
    rd_addr = 12'h304; wr_en = 1'b1; wr_addr = 12'h304; wr_data = 64'h8;
    #0.5;
    check("R11", "same-cycle read old", {rd_hit, rd_data}, old_v);
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(12'h304, 64'h8);
    #0.5;
    check("R11", "next-cycle read new", {rd_hit, rd_data}, model_rd(12'h304));
    repeat (3) @(negedge clk);
    check_all("R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_r1();
    t_mstat_r6_r7();
    t_irq_r5();
    t_sview_r2_r4();
    t_uview_r3();
    t_fp_r8();
    t_absent_r9();
    t_unknown_r10();
    t_timing_r11();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule